// File: doc/BRIEF.md
# Paired-Byte I2C Port Expander Slave

This block is an I2C target that runs from a fast system clock and oversamples the bus. It connects a 16-bit output latch and a 16-bit input sample to a two-wire host. The 7-bit target address is a fixed 4-bit prefix followed by three strap inputs. A write moves a stream of bytes into the latch. Each byte goes to one half of the latch, and the target half switches between low and high with every byte. A read returns the sampled pin values in the same order. There is no register pointer.

The serial data line is driven as an open-drain enable only. The block never drives it high. Two one-cycle pulses mark the acknowledge slots of read and write transfers. A neighbouring interrupt circuit uses them to clear its pending state. Start and Stop are taken from the synchronized bus lines. A repeated Start at any point sends the block back to address reception.

Top module: `i2c_pair_expander`

## Requirements
- R1: The block acknowledges (`sdaPullLow` high during the ninth SCL high phase) only an address byte whose upper seven bits, MSB first, equal binary 0100 followed by `strap[2:0]`. Bit 0 of that byte selects the direction: 0 is write, 1 is read. Any other address gets no acknowledge, and the block drives nothing for the rest of that transfer.
- R2: The general call address (seven zero bits) is never acknowledged.
- R3: In a write, every data byte is acknowledged. The bytes go to `portOut[7:0]`, `portOut[15:8]`, `portOut[7:0]`, and so on, with no limit on the count. The first serial bit lands in bit 7 of its lane.
- R4: A data byte updates its lane at the SCL rise of its own acknowledge slot. Until then `portOut` keeps its previous value, and the other lane is not touched.
- R5: A Stop in the middle of a byte discards the partial byte. `portOut` keeps the value from the most recent acknowledge.
- R6: In a read, the block sends `pinIn[7:0]` and then `pinIn[15:8]`, alternating, MSB first, as long as the host acknowledges.
- R7: When the host does not acknowledge a read byte, the block releases SDA (`sdaPullLow` low) and drives nothing until the next Start.
- R8: Each read byte is taken from the value `pinIn` had at the SCL fall that begins that byte's first bit. Later pin changes appear only in the following bytes.
- R9: A repeated Start sends the block back to address reception, and the next data byte goes to the low lane again.
- R10: After reset, `portOut` is 16'hFFFF, SDA is released, and both pulses are low.
- R11: `wrAckPulse` is high for one clock after the SCL fall that ends the acknowledge of each accepted write data byte. `rdAckPulse` is high for one clock at the ninth SCL rise of the address byte of a read and of every read data byte. The two pulses never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| strap | input | 3 | Low three address bits |
| pinIn | input | 16 | Port pin levels sampled for reads |
| sdaPullLow | output | 1 | Open-drain enable; 1 pulls SDA low |
| portOut | output | 16 | Output latch, low lane in bits 7:0 |
| rdAckPulse | output | 1 | One-cycle pulse at read acknowledge slots |
| wrAckPulse | output | 1 | One-cycle pulse after each write data acknowledge |

## Verification
The address is swept over all 128 values with a fixed strap, then over all eight strap settings with a matching prefix. This separates prefix decoding, strap decoding and general call rejection. Write streams use byte values computed arithmetically, with a check after every byte, so a wrong lane order, a wrong bit order or a commit that lands early or late on the wrong lane shows up as a mismatch. A read returns a pattern whose two halves differ, and the pins are changed between bytes, which separates the lane order from the capture instant. A Stop in the middle of a byte, a repeated Start after an odd number of bytes, and a read to a non-matching address each check that a partial or foreign transfer changes nothing.

// File: rtl/expander_pkg.sv
package expander_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BITS,
    ST_WR_ACK,
    ST_RD_BITS,
    ST_RD_ACK
  } busState_e;

  // strobes issued by control, consumed by the datapath
  typedef struct packed {
    logic shiftIn;   // take sampled SDA into the byte register
    logic shiftOut;  // advance the transmit byte by one bit
    logic loadPins;  // capture one pin lane into the byte register
    logic commit;    // copy the byte register into one latch lane
  } strobe_t;
endpackage

// File: rtl/exp_bus_sync.sv
module exp_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaBit,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;
  logic sclNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[STAGES-1];
      sdaPrev <= sdaPipe[STAGES-1];
    end
  end

  assign sclNow   = sclPipe[STAGES-1];
  assign sdaBit   = sdaPipe[STAGES-1];
  assign sclRise  = sclNow & ~sclPrev;
  assign sclFall  = ~sclNow & sclPrev;
  assign startDet = sclNow & sclPrev & sdaPrev & ~sdaBit;
  assign stopDet  = sclNow & sclPrev & ~sdaPrev & sdaBit;
endmodule

// File: rtl/exp_ctrl.sv
module exp_ctrl
  import expander_pkg::*;
#(
  parameter int STRAP_W = 3,
  parameter logic [6-STRAP_W:0] ADDR_PREFIX = 4'b0100,
  parameter int LANES = 2,
  parameter int LANE_W = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclRise,
  input  logic               sclFall,
  input  logic               sdaBit,
  input  logic               startDet,
  input  logic               stopDet,
  input  logic [STRAP_W-1:0] strap,
  input  logic [BYTE_W-1:0]  rxByte,
  input  logic               txMsb,
  output strobe_t            stb,
  output logic [LANE_W-1:0]  laneSel,
  output logic               sdaPullLow,
  output logic               rdAckPulse,
  output logic               wrAckPulse
);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  busState_e state, stateN;
  logic [BIT_W-1:0]  bitCnt, bitCntN;
  logic [LANE_W-1:0] lane, laneN, laneInc;
  logic byteFull, byteFullN;
  logic isRead, isReadN;
  logic rdP, wrP;
  logic addrHit;

  assign addrHit = (rxByte[BYTE_W-1:1] == {ADDR_PREFIX, strap});
  assign laneInc = (lane == LAST_LANE) ? '0 : lane + LANE_W'(1);

  always_comb begin
    stateN    = state;
    bitCntN   = bitCnt;
    laneN     = lane;
    byteFullN = byteFull;
    isReadN   = isRead;
    stb       = '0;
    rdP       = 1'b0;
    wrP       = 1'b0;
    if (startDet) begin
      stateN    = ST_ADDR;
      bitCntN   = '0;
      byteFullN = 1'b0;
      laneN     = '0;
    end else if (stopDet) begin
      stateN    = ST_IDLE;
      byteFullN = 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_WR_BITS: begin
          if (sclRise) begin
            stb.shiftIn = 1'b1;
            if (bitCnt == LAST_BIT) byteFullN = 1'b1;
            else bitCntN = bitCnt + BIT_W'(1);
          end else if (sclFall && byteFull) begin
            byteFullN = 1'b0;
            bitCntN   = '0;
            if (state == ST_WR_BITS) begin
              stateN = ST_WR_ACK;
            end else if (addrHit) begin
              stateN  = ST_ADDR_ACK;
              isReadN = rxByte[0];
            end else begin
              stateN = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclRise && isRead) rdP = 1'b1;
          if (sclFall) begin
            laneN   = '0;
            bitCntN = '0;
            if (isRead) begin
              stb.loadPins = 1'b1;
              stateN = ST_RD_BITS;
            end else begin
              stateN = ST_WR_BITS;
            end
          end
        end
        ST_WR_ACK: begin
          if (sclRise) stb.commit = 1'b1;
          if (sclFall) begin
            wrP    = 1'b1;
            laneN  = laneInc;
            stateN = ST_WR_BITS;
          end
        end
        ST_RD_BITS: begin
          if (sclFall) begin
            stb.shiftOut = 1'b1;
            if (bitCnt == LAST_BIT) begin
              stateN  = ST_RD_ACK;
              bitCntN = '0;
            end else begin
              bitCntN = bitCnt + BIT_W'(1);
            end
          end
        end
        ST_RD_ACK: begin
          if (sclRise) begin
            rdP = 1'b1;
            if (sdaBit) stateN = ST_IDLE;
          end else if (sclFall) begin
            laneN        = laneInc;
            stb.loadPins = 1'b1;
            stateN       = ST_RD_BITS;
          end
        end
        default: ;
      endcase
    end
  end

  assign laneSel = laneN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      lane       <= '0;
      byteFull   <= 1'b0;
      isRead     <= 1'b0;
      rdAckPulse <= 1'b0;
      wrAckPulse <= 1'b0;
    end else begin
      state      <= stateN;
      bitCnt     <= bitCntN;
      lane       <= laneN;
      byteFull   <= byteFullN;
      isRead     <= isReadN;
      rdAckPulse <= rdP;
      wrAckPulse <= wrP;
    end
  end

  assign sdaPullLow = (state == ST_ADDR_ACK) || (state == ST_WR_ACK) ||
                      ((state == ST_RD_BITS) && !txMsb);

  // R7: a Stop always leaves the line released
  a_r7_release_after_stop: assert property (@(posedge clk) disable iff (!rstN)
    $past(stopDet) |-> !sdaPullLow);
  // R9: a Start always leaves the line released while the address arrives
  a_r9_release_after_start: assert property (@(posedge clk) disable iff (!rstN)
    $past(startDet) |-> !sdaPullLow);
  // R11: the two acknowledge pulses never coincide
  a_r11_pulses_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(rdAckPulse && wrAckPulse));
  // R11: a write pulse always follows a bus clock fall
  a_r11_wr_after_fall: assert property (@(posedge clk) disable iff (!rstN)
    wrAckPulse |-> $past(sclFall));
  // R11: a read pulse always follows a bus clock rise
  a_r11_rd_after_rise: assert property (@(posedge clk) disable iff (!rstN)
    rdAckPulse |-> $past(sclRise));
endmodule

// File: rtl/exp_dpath.sv
module exp_dpath
  import expander_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int LANES = 2,
  parameter int LANE_W = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [LANE_W-1:0] laneSel,
  input  logic              sdaBit,
  input  logic [PORT_W-1:0] pinIn,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txMsb,
  output logic [PORT_W-1:0] portOut
);
  logic [SYNC_STAGES-1:0][PORT_W-1:0] pinPipe;
  logic [PORT_W-1:0] pinNow;
  logic [BYTE_W-1:0] byteReg;
  logic [PORT_W-1:0] portLatch;

  always_ff @(posedge clk) begin
    if (!rstN) pinPipe <= '1;
    else       pinPipe <= {pinPipe[SYNC_STAGES-2:0], pinIn};
  end
  assign pinNow = pinPipe[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteReg <= '1;
    end else if (stb.loadPins) begin
      byteReg <= pinNow[int'(laneSel)*BYTE_W +: BYTE_W];
    end else if (stb.shiftIn) begin
      byteReg <= {byteReg[BYTE_W-2:0], sdaBit};
    end else if (stb.shiftOut) begin
      byteReg <= {byteReg[BYTE_W-2:0], 1'b1};
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_ff @(posedge clk) begin
      if (!rstN) begin
        portLatch[g*BYTE_W +: BYTE_W] <= '1;
      end else if (stb.commit && (laneSel == LANE_W'(g))) begin
        portLatch[g*BYTE_W +: BYTE_W] <= byteReg;
      end
    end
  end

  assign rxByte  = byteReg;
  assign txMsb   = byteReg[BYTE_W-1];
  assign portOut = portLatch;

  // R4: the latch moves only on a commit strobe from control
  a_r4_latch_on_commit: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(portLatch) |-> $past(stb.commit));
  // R4: a commit never lands during a pin capture
  a_r4_commit_not_load: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.commit && stb.loadPins));
endmodule

// File: rtl/i2c_pair_expander.sv
module i2c_pair_expander
  import expander_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int STRAP_W = 3,
  parameter logic [6-STRAP_W:0] ADDR_PREFIX = 4'b0100,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] strap,
  input  logic [PORT_W-1:0]  pinIn,
  output logic               sdaPullLow,
  output logic [PORT_W-1:0]  portOut,
  output logic               rdAckPulse,
  output logic               wrAckPulse
);
  localparam int LANES  = PORT_W / BYTE_W;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic sdaBit, sclRise, sclFall, startDet, stopDet;
  logic [BYTE_W-1:0] rxByte;
  logic txMsb;
  logic [LANE_W-1:0] laneSel;
  strobe_t stb;

  exp_bus_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaBit(sdaBit), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  exp_ctrl #(
    .STRAP_W(STRAP_W), .ADDR_PREFIX(ADDR_PREFIX),
    .LANES(LANES), .LANE_W(LANE_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .sdaBit(sdaBit), .startDet(startDet), .stopDet(stopDet),
    .strap(strap), .rxByte(rxByte), .txMsb(txMsb), .stb(stb),
    .laneSel(laneSel), .sdaPullLow(sdaPullLow),
    .rdAckPulse(rdAckPulse), .wrAckPulse(wrAckPulse)
  );

  exp_dpath #(
    .PORT_W(PORT_W), .LANES(LANES), .LANE_W(LANE_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .laneSel(laneSel),
    .sdaBit(sdaBit), .pinIn(pinIn), .rxByte(rxByte),
    .txMsb(txMsb), .portOut(portOut)
  );
endmodule

// File: tb/tb_i2c_pair_expander.sv
`timescale 1ns/1ps
module tb_i2c_pair_expander;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic [2:0] strap = 3'd5;
  logic [15:0] pinIn = 16'h0000;
  logic sdaPullLow, rdAckPulse, wrAckPulse;
  logic [15:0] portOut;
  logic sdaLine;
  int total = 0;
  int bad = 0;
  int rdCnt = 0;
  int wrCnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  assign sdaLine = sdaM & ~sdaPullLow;

  i2c_pair_expander dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .strap(strap),
    .pinIn(pinIn), .sdaPullLow(sdaPullLow), .portOut(portOut),
    .rdAckPulse(rdAckPulse), .wrAckPulse(wrAckPulse)
  );

  always @(posedge clk) begin
    if (rdAckPulse) rdCnt <= rdCnt + 1;
    if (wrAckPulse) wrCnt <= wrCnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart;
    sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(Q);
    sdaM = 1'b0; tick(Q); sclM = 1'b0; tick(Q);
  endtask

  task automatic busStop;
    sdaM = 1'b0; tick(Q); sclM = 1'b1; tick(Q); sdaM = 1'b1; tick(Q);
  endtask

  task automatic putBit(input logic b);
    sdaM = b; tick(Q); sclM = 1'b1; tick(2 * Q); sclM = 1'b0; tick(Q);
  endtask

  task automatic getBit(output logic b);
    sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(Q);
    b = sdaLine; tick(Q); sclM = 1'b0; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] v, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) putBit(v[i]);
    getBit(b);
    ack = !b;
  endtask

  task automatic recvByte(output logic [7:0] v, input bit ackIt);
    for (int i = 7; i >= 0; i--) getBit(v[i]);
    putBit(!ackIt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] rb;
    logic [15:0] expLatch;
    int rd0, wr0;
    tick(5);
    rstN = 1'b1;
    tick(3);
    // R10: reset state
    chk(portOut == 16'hFFFF, "R10 latch", portOut, 16'hFFFF);
    chk(sdaPullLow == 1'b0, "R10 sda", sdaPullLow, 0);
    chk(!rdAckPulse && !wrAckPulse, "R10 pulses", {rdAckPulse, wrAckPulse}, 0);

    // R1/R2: every address with strap 5
    for (int a = 0; a < 128; a++) begin
      busStart;
      sendByte({a[6:0], 1'b0}, ack);
      busStop;
      chk(ack == (a == 7'h25), (a == 0) ? "R2 general call" : "R1 address sweep",
          ack, a == 7'h25);
    end
    // R1: every strap with the matching prefix
    for (int s = 0; s < 8; s++) begin
      strap = s[2:0];
      tick(Q);
      busStart;
      sendByte({4'b0100, s[2:0], 1'b0}, ack);
      busStop;
      chk(ack, "R1 strap sweep", ack, 1);
    end
    strap = 3'd5;
    chk(portOut == 16'hFFFF, "R1 address-only leaves latch", portOut, 16'hFFFF);

    // R3/R4: stream of six bytes, alternating lanes
    expLatch = 16'hFFFF;
    busStart;
    sendByte(8'h4A, ack);
    for (int k = 0; k < 6; k++) begin
      logic [7:0] v;
      v = 8'((k * 37 + 11) ^ (k << 5));
      sendByte(v, ack);
      chk(ack, "R3 data ack", ack, 1);
      if (k % 2 == 0) expLatch[7:0] = v; else expLatch[15:8] = v;
      chk(portOut == expLatch, "R4 per-byte commit", portOut, expLatch);
    end
    busStop;

    // R5: partial byte then Stop
    busStart;
    sendByte(8'h4A, ack);
    sendByte(8'h81, ack);
    expLatch[7:0] = 8'h81;
    for (int i = 0; i < 4; i++) putBit(1'b0);
    chk(portOut == expLatch, "R4 mid-byte unchanged", portOut, expLatch);
    busStop;
    tick(Q);
    chk(portOut == expLatch, "R5 stop discards partial", portOut, expLatch);

    // R9: repeated start after one byte goes back to low lane
    busStart;
    sendByte(8'h4A, ack);
    sendByte(8'h77, ack);
    busStart;
    sendByte(8'h4A, ack);
    sendByte(8'h88, ack);
    busStop;
    expLatch[7:0] = 8'h88;
    chk(portOut == expLatch, "R9 repeated start lane", portOut, expLatch);

    // R11: write pulses
    rd0 = rdCnt; wr0 = wrCnt;
    busStart;
    sendByte(8'h4A, ack);
    sendByte(8'h3C, ack);
    sendByte(8'hC3, ack);
    busStop;
    expLatch = 16'hC33C;
    chk(wrCnt - wr0 == 2, "R11 write pulse count", wrCnt - wr0, 2);
    chk(rdCnt == rd0, "R11 no read pulse in write", rdCnt - rd0, 0);

    // R6/R7: read alternates lanes
    pinIn = 16'hA53C;
    tick(Q);
    rd0 = rdCnt; wr0 = wrCnt;
    busStart;
    sendByte(8'h4B, ack);
    chk(ack, "R1 read address ack", ack, 1);
    for (int k = 0; k < 4; k++) begin
      recvByte(rb, k != 3);
      chk(rb == ((k % 2 == 0) ? 8'h3C : 8'hA5), "R6 read order", rb,
          (k % 2 == 0) ? 8'h3C : 8'hA5);
    end
    chk(sdaPullLow == 1'b0, "R7 released after nack", sdaPullLow, 0);
    getBit(rb[0]);
    chk(rb[0] == 1'b1, "R7 no drive after nack", rb[0], 1);
    busStop;
    chk(rdCnt - rd0 == 5, "R11 read pulse count", rdCnt - rd0, 5);
    chk(wrCnt == wr0, "R11 no write pulse in read", wrCnt - wr0, 0);

    // R8: capture instant
    pinIn = 16'h1234;
    tick(Q);
    busStart;
    sendByte(8'h4B, ack);
    recvByte(rb, 1'b1);
    chk(rb == 8'h34, "R8 first byte", rb, 8'h34);
    pinIn = 16'h9876;
    recvByte(rb, 1'b1);
    chk(rb == 8'h12, "R8 high byte captured earlier", rb, 8'h12);
    recvByte(rb, 1'b0);
    chk(rb == 8'h76, "R8 new pins in next byte", rb, 8'h76);
    busStop;

    // R1: read to a foreign address is ignored
    busStart;
    sendByte(8'h4D, ack);
    chk(!ack, "R1 foreign read nack", ack, 0);
    recvByte(rb, 1'b0);
    chk(rb == 8'hFF, "R1 foreign read no drive", rb, 8'hFF);
    busStop;
    chk(portOut == expLatch, "R1 latch kept", portOut, expLatch);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule